// File: doc/BRIEF.md
# Two-Clock Frequency Comparator

This block takes two clocks that run freely and have no fixed relation to each other, and reports which one is faster. A `start` pulse in the reference (A) domain opens a gate. The gate stays high for a fixed power-of-two number of A cycles. A two-flop synchronizer carries the gate into the B domain. While the synchronized gate is high, a counter clocked by B counts its cycles. The B tally is then compared with the gate length, which serves as the A tally.

When the gate closes, the B side freezes its tally and flips a toggle flag. The flag crosses back to the A domain through a second synchronizer. The A side reads the frozen tally only once the flag has arrived, so the multi-bit value is always stable when it is sampled. A guard band around the gate length absorbs the few cycles of uncertainty that the synchronizers add at each gate edge. Tallies inside the band are reported as equal.

The verdict is valid while `done` is high, and `done` is high for exactly one A cycle. `busy` covers the whole measurement. Each domain has its own synchronous, active-high reset.

Top module: `clk_race_cmp`

## Requirements
- R1: While both resets are held, and directly after they are released, `done`, `busy` and `result` are all 0.
- R2: A `start` pulse accepted while idle raises `busy` on the next A edge. The gate is then high for exactly 2^WIN_LOG2 consecutive A cycles.
- R3: The B tally is loaded with 1 on the first B cycle in which the synchronized gate is high. It then rises by one for each further B cycle in which that gate is high, and holds its value while the gate is low. With equal clock periods, the tally therefore equals the gate length exactly.
- R4: `result` is 2'b01 (A faster) when the B tally is below the gate length minus GUARD.
- R5: `result` is 2'b10 (B faster) when the B tally is above the gate length plus GUARD.
- R6: `result` is 2'b00 (equal) when the B tally is within GUARD of the gate length, limits included. The value 2'b11 never appears with `done`.
- R7: `done` is high for one A cycle, and `busy` is already low in that cycle. `result` keeps its value until the next `done`.
- R8: A `start` that arrives while `busy` is high is ignored. It does not restart the gate and does not cause a second `done`.
- R9: On gate close, the B side flips a toggle flag, and only that flag's arrival in the A domain produces `done`. From an accepted `start` to `done` takes between 2^WIN_LOG2+3 and 2^WIN_LOG2+20 A cycles when the clock periods are similar.
- R10: Measurements can follow one another. Each new measurement starts from a cleared tally and reports its own verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Reference clock; the gate is timed in its cycles |
| rst_a | input | 1 | Synchronous active-high reset, A domain |
| clk_b | input | 1 | Clock under comparison |
| rst_b | input | 1 | Synchronous active-high reset, B domain |
| start | input | 1 | One-cycle request in the A domain to begin a measurement |
| busy | output | 1 | High from the accepted start until the verdict |
| done | output | 1 | One-cycle pulse marking `result` valid |
| result | output | 2 | 01 A faster, 10 B faster, 00 equal |

## Verification
The hardest condition to reach from the ports is a tally that lands close to the guard band. The ratio of the B and A periods sets the tally directly, so the bench places it there by choosing the B half-period. Some periods put the expected tally about two counts from the gate length, and others put it six to eight counts away on either side. Every such period keeps the synchronizer's ±1 quantization away from a band edge. A stray `start` is also injected halfway through an open gate. This shows that the gate is not stretched: the `start`-to-`done` latency stays in the single-run range, and no second `done` follows.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    VERDICT_EQ = 2'b00,
    VERDICT_A  = 2'b01,
    VERDICT_B  = 2'b10
  } verdict_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_OPEN,
    PH_WAIT
  } phase_e;

  // Classify a B tally against the gate length with a symmetric guard band.
  function automatic verdict_e judge(input logic [31:0] tally,
                                     input logic [31:0] gate_len,
                                     input logic [31:0] guard);
    if (tally > gate_len + guard)
      return VERDICT_B;
    else if (tally + guard < gate_len)
      return VERDICT_A;
    else
      return VERDICT_EQ;
  endfunction

endpackage

// File: rtl/fcmp_sync.sv
module fcmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/fcmp_gate_gen.sv
module fcmp_gate_gen
  import fcmp_pkg::*;
#(
  parameter int WIN_LOG2 = 23
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                arrive,
  output logic                gate,
  output logic                busy,
  output logic [WIN_LOG2-1:0] gate_cnt
);
  localparam logic [WIN_LOG2-1:0] LAST = '1;

  phase_e phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      gate     <= 1'b0;
      gate_cnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase    <= PH_OPEN;
          gate     <= 1'b1;
          gate_cnt <= '0;
        end
        PH_OPEN: if (gate_cnt == LAST) begin
          phase <= PH_WAIT;
          gate  <= 1'b0;
        end else begin
          gate_cnt <= gate_cnt + 1'b1;
        end
        PH_WAIT: if (arrive) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/fcmp_b_tally.sv
module fcmp_b_tally #(
  parameter int CNT_W  = 25,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_async,
  output logic             gate_s,
  output logic             gate_rise,
  output logic             gate_fall,
  output logic [CNT_W-1:0] tally,
  output logic             flag
);
  logic gate_d;

  fcmp_sync #(.STAGES(STAGES)) gate_sync_i (
    .clk(clk), .rst(rst), .d(gate_async), .q(gate_s)
  );

  assign gate_rise = gate_s & ~gate_d;
  assign gate_fall = ~gate_s & gate_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_d <= 1'b0;
      tally  <= '0;
      flag   <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (gate_rise)   tally <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (gate_s) tally <= tally + 1'b1;
      if (gate_fall)   flag  <= ~flag;
    end
  end
endmodule

// File: rtl/clk_race_cmp.sv
module clk_race_cmp
  import fcmp_pkg::*;
#(
  parameter int WIN_LOG2 = 23,
  parameter int GUARD    = 4,
  parameter int STAGES   = 2
) (
  input  logic       clk_a,
  input  logic       rst_a,
  input  logic       clk_b,
  input  logic       rst_b,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic [1:0] result
);
  localparam int CNT_W = WIN_LOG2 + 2;
  localparam logic [31:0] GATE_LEN = 32'(1) << WIN_LOG2;

  logic                a_gate;
  logic [WIN_LOG2-1:0] a_cnt;
  logic                a_flag_s;
  logic                a_flag_d;
  logic                a_arrive;
  logic                b_gate_s;
  logic                b_rise;
  logic                b_fall;
  logic [CNT_W-1:0]    b_tally;
  logic                b_flag;

  fcmp_gate_gen #(.WIN_LOG2(WIN_LOG2)) gate_i (
    .clk(clk_a), .rst(rst_a), .start(start), .arrive(a_arrive),
    .gate(a_gate), .busy(busy), .gate_cnt(a_cnt)
  );

  fcmp_b_tally #(.CNT_W(CNT_W), .STAGES(STAGES)) tally_i (
    .clk(clk_b), .rst(rst_b), .gate_async(a_gate),
    .gate_s(b_gate_s), .gate_rise(b_rise), .gate_fall(b_fall),
    .tally(b_tally), .flag(b_flag)
  );

  fcmp_sync #(.STAGES(STAGES)) flag_sync_i (
    .clk(clk_a), .rst(rst_a), .d(b_flag), .q(a_flag_s)
  );

  assign a_arrive = a_flag_s ^ a_flag_d;

  always_ff @(posedge clk_a) begin
    if (rst_a) begin
      a_flag_d <= 1'b0;
      done     <= 1'b0;
      result   <= VERDICT_EQ;
    end else begin
      a_flag_d <= a_flag_s;
      done     <= a_arrive;
      if (a_arrive) result <= judge(32'(b_tally), GATE_LEN, 32'(GUARD));
    end
  end
endmodule

// File: rtl/fcmp_chk.sv
module fcmp_chk #(
  parameter int WIN_LOG2 = 23,
  parameter int CNT_W    = 25
) (
  input logic                clk_a,
  input logic                rst_a,
  input logic                clk_b,
  input logic                rst_b,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [1:0]          result,
  input logic                a_gate,
  input logic [WIN_LOG2-1:0] a_cnt,
  input logic                a_arrive,
  input logic                b_gate_s,
  input logic                b_rise,
  input logic                b_fall,
  input logic [CNT_W-1:0]    b_tally,
  input logic                b_flag
);
  // R2
  gate_len_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    $fell(a_gate) |-> $past(a_cnt) == {WIN_LOG2{1'b1}});

  // R2
  start_busy_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    (start && !busy) |=> (busy && a_gate));

  // R8
  no_restart_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_gate && start && !(&a_cnt)) |=> a_cnt == $past(a_cnt) + 1'b1);

  // R3
  tally_load_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    b_rise |=> b_tally == {{(CNT_W-1){1'b0}}, 1'b1});

  // R3
  tally_hold_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    !b_gate_s |=> $stable(b_tally));

  // R9
  flag_flip_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    b_fall |=> b_flag != $past(b_flag));

  // R9
  done_after_arrive_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    a_arrive |=> done);

  // R7
  done_pulse_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    done |-> !busy);

  // R7
  result_hold_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    !done |-> $stable(result));

  // R6
  code_legal_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    done |-> result != 2'b11);
endmodule

bind clk_race_cmp fcmp_chk #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) chk_i (
  .clk_a(clk_a), .rst_a(rst_a), .clk_b(clk_b), .rst_b(rst_b),
  .start(start), .busy(busy), .done(done), .result(result),
  .a_gate(a_gate), .a_cnt(a_cnt), .a_arrive(a_arrive),
  .b_gate_s(b_gate_s), .b_rise(b_rise), .b_fall(b_fall),
  .b_tally(b_tally), .b_flag(b_flag)
);

// File: tb/clk_race_cmp_tb_top.sv
`timescale 1ns/1ps
module clk_race_cmp_tb_top;
  localparam int WIN_LOG2 = 8;
  localparam int GUARD    = 4;
  localparam int GATE     = 1 << WIN_LOG2;
  localparam real TA_HALF = 2.0;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_a = 1'b1;
  logic rst_b = 1'b1;
  logic start = 1'b0;
  logic busy, done;
  logic [1:0] result;
  real  half_b = 2.0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  clk_race_cmp #(.WIN_LOG2(WIN_LOG2), .GUARD(GUARD)) dut_i (
    .clk_a(clk_a), .rst_a(rst_a), .clk_b(clk_b), .rst_b(rst_b),
    .start(start), .busy(busy), .done(done), .result(result)
  );

  always #(TA_HALF) clk_a = ~clk_a;
  initial begin
    #0.7;
    forever #(half_b) clk_b = ~clk_b;
  end

  always @(posedge clk_a) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected verdict from the period ratio: 1 = A faster, 2 = B faster, 0 = equal
  function automatic int expect_code(input real hb);
    real est;
    est = GATE * TA_HALF / hb;
    if (est > GATE + GUARD + 1.5) return 2;
    if (est < GATE - GUARD - 1.5) return 1;
    return 0;
  endfunction

  task automatic pulse_start();
    @(negedge clk_a); start = 1'b1;
    @(negedge clk_a); start = 1'b0;
  endtask

  // Waits for done; returns the A cycles after the start pulse, -1 on timeout
  task automatic wait_done(output int lat);
    lat = -1;
    for (int i = 1; i < 4 * GATE; i++) begin
      @(negedge clk_a);
      if (done) begin lat = i; break; end
    end
  endtask

  task automatic do_reset();
    rst_a = 1'b1; rst_b = 1'b1;
    repeat (6) @(negedge clk_a);
    check(done == 0 && busy == 0 && result == 2'b00, "R1 during reset",
          {done, busy, result}, 0);
    rst_a = 1'b0; rst_b = 1'b0;
    @(negedge clk_a);
    check(done == 0 && busy == 0 && result == 2'b00, "R1 after reset",
          {done, busy, result}, 0);
  endtask

  task automatic measure(input real hb, input string tag);
    int lat;
    int exp;
    half_b = hb;
    exp = expect_code(hb);
    repeat (4) @(negedge clk_a);
    pulse_start();
    check(busy == 1, "R2 busy after start", busy, 1);
    wait_done(lat);
    check(lat >= GATE + 3 && lat <= GATE + 20, "R9 start-to-done latency", lat, GATE + 8);
    check(busy == 0, "R7 busy low with done", busy, 0);
    check(int'(result) == exp, tag, result, exp);
    @(negedge clk_a);
    check(done == 0, "R7 done single cycle", done, 0);
    repeat (5) @(negedge clk_a);
    check(int'(result) == exp, "R7 result held", result, exp);
  endtask

  task automatic test_ignore_start();
    int lat;
    half_b = 2.0;
    repeat (4) @(negedge clk_a);
    pulse_start();
    repeat (GATE / 2) @(negedge clk_a);
    start = 1'b1; @(negedge clk_a); start = 1'b0;
    lat = -1;
    for (int i = 1; i < 4 * GATE; i++) begin
      @(negedge clk_a);
      if (done) begin lat = i + GATE / 2 + 1; break; end
    end
    check(lat >= GATE + 3 && lat <= GATE + 20, "R8 gate not restarted", lat, GATE + 8);
    check(result == 2'b00, "R8 verdict equal", result, 0);
    lat = 0;
    for (int i = 0; i < GATE + 40; i++) begin
      @(negedge clk_a);
      if (done) lat++;
    end
    check(lat == 0 && busy == 0, "R8 no second done", lat, 0);
  endtask

  initial begin
    do_reset();
    measure(2.0,   "R3 equal periods give exact tally, verdict equal");
    measure(1.8,   "R5 B clearly faster");
    measure(2.25,  "R4 A clearly faster");
    measure(2.015, "R6 tally inside guard band reports equal");
    measure(1.95,  "R5 tally just past upper guard");
    measure(2.06,  "R4 tally just past lower guard");
    measure(1.8,   "R10 back-to-back B faster");
    measure(2.25,  "R10 back-to-back A faster after B run");
    test_ignore_start();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule